// File: doc/BRIEF.md
# ACPI Event and SCI Controller

This block gathers fixed power-management events and hotplug general-purpose events into status registers. It masks them with enable registers and drives a registered, level-sensitive system control interrupt (SCI). Each status bit is set by a hardware event input and cleared by software through a write-one-to-clear access on a byte-wide register port. The same port also reaches the enable bytes and a read-only view of the ACPI mode bit.

A strobe from the APM control port carries a command byte. One command value turns ACPI mode on and another turns it off. Every such write can also produce a one-cycle SMI pulse, which depends on a bit of an SMI configuration byte. A timer-arm output tells an external timer block when an overflow would be useful: the timer enable bit is set and its status bit is still clear.

Top module: `acpi_sci_ctrl`

## Requirements
- R1: After reset all status bits, enable bits and the ACPI mode bit are 0, `sci`, `smiPulse` and `timerArm` are low, and every register reads 0.
- R2: `sci` is high when the PM1 status word ANDed with the PM1 enable word has bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC) set. It is registered and follows a change of status or enable one clock later.
- R3: `sci` is also high when the GPE status byte ANDed with the GPE enable byte has bit 1 (PCI hotplug) or bit 2 (CPU hotplug) set. Other GPE enable bits never raise `sci`.
- R4: Writing a status byte clears each status bit whose data bit is 1. Data bits that are 0 leave the status unchanged.
- R5: A hardware set of a status bit in the same cycle as a software clear of that bit wins, and the bit stays 1.
- R6: Event inputs set status bits: `tmrOvfEvt` sets PM1 bit 0, `gblLockEvt` sets bit 5, `pwrDownReq` sets bit 8 and `rtcEvt` sets bit 10. `pciHpEvt` sets GPE bit 1 and `cpuHpEvt` sets GPE bit 2.
- R7: An APM write of 0xF1 sets the ACPI mode bit and a write of 0xF0 clears it. Any other value leaves it unchanged. The bit appears on `acpiMode` one clock after the write and reads as bit 0 of address 6.
- R8: Each APM write gives a `smiPulse` of exactly one cycle, in the next cycle, if and only if bit 1 of `smiCfg` is set at the write.
- R9: `timerArm` is high exactly while PM1 enable bit 0 is 1 and PM1 status bit 0 is 0.
- R10: Register map: address 0/1 hold the PM1 status low/high byte, 2/3 the PM1 enable low/high byte, 4 the GPE status byte, 5 the GPE enable byte, 6 the ACPI mode bit (read-only) and 7 is reserved. Only PM1 bits 0, 5, 8 and 10 are stored. Other PM1 bits and address 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| apmWrEn | input | 1 | APM control-port write strobe |
| apmData | input | 8 | APM command byte |
| smiCfg | input | 8 | SMI configuration byte |
| tmrOvfEvt | input | 1 | Timer overflow event |
| gblLockEvt | input | 1 | Global lock release event |
| pwrDownReq | input | 1 | Power-down request |
| rtcEvt | input | 1 | RTC alarm event |
| pciHpEvt | input | 1 | PCI hotplug event |
| cpuHpEvt | input | 1 | CPU hotplug event |
| sci | output | 1 | Level SCI output |
| smiPulse | output | 1 | One-cycle SMI pulse |
| acpiMode | output | 1 | ACPI mode bit |
| timerArm | output | 1 | Timer arm request |

## Verification
The assertions check on every cycle that a hardware set always leaves its status bit at 1 and that a clear without a competing set removes it. They also check that an enabled power-button status raises `sci` on the next edge, that the ACPI on/off strobes move the mode bit, and that an SMI pulse always goes back to an APM write with the SMI bit set. The bench scenarios cover the rest. Those are: the exact masking of all enable patterns against both interrupt sources, the exhaustive sweep of APM command bytes under both SMI settings, the register map with its unimplemented bits, and the timer-arm levels.

// File: rtl/acpi_sci_pkg.sv
package acpi_sci_pkg;
  localparam int PM1_W   = 16;
  localparam int GPE_W   = 8;
  localparam int BIT_TMR = 0;
  localparam int BIT_GBL = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_RTC = 10;
  localparam int GPE_PCI = 1;
  localparam int GPE_CPU = 2;

  localparam logic [PM1_W-1:0] PM1_IMPL =
    (16'd1 << BIT_TMR) | (16'd1 << BIT_GBL) | (16'd1 << BIT_PWR) | (16'd1 << BIT_RTC);
  localparam logic [PM1_W-1:0] PM1_SCI = PM1_IMPL;
  localparam logic [GPE_W-1:0] GPE_SCI = (8'd1 << GPE_PCI) | (8'd1 << GPE_CPU);

  localparam int ADR_STS_LO = 0;
  localparam int ADR_STS_HI = 1;
  localparam int ADR_EN_LO  = 2;
  localparam int ADR_EN_HI  = 3;
  localparam int ADR_GSTS   = 4;
  localparam int ADR_GEN    = 5;
  localparam int ADR_MODE   = 6;

  typedef struct packed {
    logic       wrStsLo;
    logic       wrStsHi;
    logic       wrEnLo;
    logic       wrEnHi;
    logic       wrGpeSts;
    logic       wrGpeEn;
    logic       acpiOn;
    logic       acpiOff;
    logic [7:0] data;
  } ctlStrobe_t;
endpackage

// File: rtl/acpi_sci_ctl.sv
module acpi_sci_ctl
  import acpi_sci_pkg::*;
#(
  parameter int         ADDR_W  = 3,
  parameter logic [7:0] ENA_CMD = 8'hF1,
  parameter logic [7:0] DIS_CMD = 8'hF0,
  parameter int         SMI_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic              apmWrEn,
  input  logic [7:0]        apmData,
  input  logic [7:0]        smiCfg,
  output ctlStrobe_t        strb,
  output logic              smiPulse
);
  localparam logic [ADDR_W-1:0] A_STS_LO = ADDR_W'(ADR_STS_LO);
  localparam logic [ADDR_W-1:0] A_STS_HI = ADDR_W'(ADR_STS_HI);
  localparam logic [ADDR_W-1:0] A_EN_LO  = ADDR_W'(ADR_EN_LO);
  localparam logic [ADDR_W-1:0] A_EN_HI  = ADDR_W'(ADR_EN_HI);
  localparam logic [ADDR_W-1:0] A_GSTS   = ADDR_W'(ADR_GSTS);
  localparam logic [ADDR_W-1:0] A_GEN    = ADDR_W'(ADR_GEN);

  always_comb begin
    strb          = '0;
    strb.data     = regWrData;
    strb.wrStsLo  = regWrEn && (regAddr == A_STS_LO);
    strb.wrStsHi  = regWrEn && (regAddr == A_STS_HI);
    strb.wrEnLo   = regWrEn && (regAddr == A_EN_LO);
    strb.wrEnHi   = regWrEn && (regAddr == A_EN_HI);
    strb.wrGpeSts = regWrEn && (regAddr == A_GSTS);
    strb.wrGpeEn  = regWrEn && (regAddr == A_GEN);
    strb.acpiOn   = apmWrEn && (apmData == ENA_CMD);
    strb.acpiOff  = apmWrEn && (apmData == DIS_CMD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) smiPulse <= 1'b0;
    else       smiPulse <= apmWrEn && smiCfg[SMI_BIT];
  end

  // R8
  smi_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    smiPulse |-> $past(apmWrEn && smiCfg[SMI_BIT]));

  // R8
  smi_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (apmWrEn && !smiCfg[SMI_BIT]) |=> !smiPulse);
endmodule

// File: rtl/acpi_sci_dp.sv
module acpi_sci_dp
  import acpi_sci_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              tmrOvfEvt,
  input  logic              gblLockEvt,
  input  logic              pwrDownReq,
  input  logic              rtcEvt,
  input  logic              pciHpEvt,
  input  logic              cpuHpEvt,
  output logic [7:0]        regRdData,
  output logic              sci,
  output logic              acpiMode,
  output logic              timerArm
);
  logic [PM1_W-1:0] pm1Set, pm1Sts, pm1En;
  logic [GPE_W-1:0] gpeSet, gpeStsQ, gpeEnQ, gpeClr;
  logic             sciQ, modeQ;

  always_comb begin
    pm1Set          = '0;
    pm1Set[BIT_TMR] = tmrOvfEvt;
    pm1Set[BIT_GBL] = gblLockEvt;
    pm1Set[BIT_PWR] = pwrDownReq;
    pm1Set[BIT_RTC] = rtcEvt;
    gpeSet          = '0;
    gpeSet[GPE_PCI] = pciHpEvt;
    gpeSet[GPE_CPU] = cpuHpEvt;
  end

  for (genvar b = 0; b < PM1_W; b++) begin : g_pm1
    if (PM1_IMPL[b]) begin : g_impl
      localparam bit IS_HI = (b >= 8);
      logic stsQ, enQ, clrHit, enWr;
      assign clrHit = (IS_HI ? strb.wrStsHi : strb.wrStsLo) && strb.data[b % 8];
      assign enWr   = IS_HI ? strb.wrEnHi : strb.wrEnLo;
      always_ff @(posedge clk) begin
        if (!rstN)          stsQ <= 1'b0;
        else if (pm1Set[b]) stsQ <= 1'b1;
        else if (clrHit)    stsQ <= 1'b0;
      end
      always_ff @(posedge clk) begin
        if (!rstN)     enQ <= 1'b0;
        else if (enWr) enQ <= strb.data[b % 8];
      end
      assign pm1Sts[b] = stsQ;
      assign pm1En[b]  = enQ;
    end else begin : g_none
      assign pm1Sts[b] = 1'b0;
      assign pm1En[b]  = 1'b0;
    end
  end

  assign gpeClr = strb.wrGpeSts ? strb.data : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gpeStsQ <= '0;
      gpeEnQ  <= '0;
    end else begin
      gpeStsQ <= gpeSet | (gpeStsQ & ~gpeClr);
      if (strb.wrGpeEn) gpeEnQ <= strb.data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             modeQ <= 1'b0;
    else if (strb.acpiOn)  modeQ <= 1'b1;
    else if (strb.acpiOff) modeQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) sciQ <= 1'b0;
    else       sciQ <= (|(pm1Sts & pm1En & PM1_SCI)) || (|(gpeStsQ & gpeEnQ & GPE_SCI));
  end

  assign sci      = sciQ;
  assign acpiMode = modeQ;
  assign timerArm = pm1En[BIT_TMR] && !pm1Sts[BIT_TMR];

  always_comb begin
    case (int'(regAddr))
      ADR_STS_LO: regRdData = pm1Sts[7:0];
      ADR_STS_HI: regRdData = pm1Sts[15:8];
      ADR_EN_LO:  regRdData = pm1En[7:0];
      ADR_EN_HI:  regRdData = pm1En[15:8];
      ADR_GSTS:   regRdData = gpeStsQ;
      ADR_GEN:    regRdData = gpeEnQ;
      ADR_MODE:   regRdData = {7'd0, modeQ};
      default:    regRdData = 8'd0;
    endcase
  end

  // R5
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    pm1Set[BIT_PWR] |=> pm1Sts[BIT_PWR]);

  // R5
  gpe_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuHpEvt |=> gpeStsQ[GPE_CPU]);

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStsLo && strb.data[BIT_TMR] && !tmrOvfEvt) |=> !pm1Sts[BIT_TMR]);

  // R2
  sci_pwr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pm1Sts[BIT_PWR] && pm1En[BIT_PWR]) |=> sci);

  // R7
  acpi_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.acpiOn |=> acpiMode);

  // R7
  acpi_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.acpiOff |=> !acpiMode);
endmodule

// File: rtl/acpi_sci_ctrl.sv
module acpi_sci_ctrl
  import acpi_sci_pkg::*;
#(
  parameter int         ADDR_W  = 3,
  parameter logic [7:0] ENA_CMD = 8'hF1,
  parameter logic [7:0] DIS_CMD = 8'hF0,
  parameter int         SMI_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              apmWrEn,
  input  logic [7:0]        apmData,
  input  logic [7:0]        smiCfg,
  input  logic              tmrOvfEvt,
  input  logic              gblLockEvt,
  input  logic              pwrDownReq,
  input  logic              rtcEvt,
  input  logic              pciHpEvt,
  input  logic              cpuHpEvt,
  output logic              sci,
  output logic              smiPulse,
  output logic              acpiMode,
  output logic              timerArm
);
  ctlStrobe_t strb;

  acpi_sci_ctl #(
    .ADDR_W(ADDR_W), .ENA_CMD(ENA_CMD), .DIS_CMD(DIS_CMD), .SMI_BIT(SMI_BIT)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .apmWrEn(apmWrEn), .apmData(apmData),
    .smiCfg(smiCfg), .strb(strb), .smiPulse(smiPulse)
  );

  acpi_sci_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .tmrOvfEvt(tmrOvfEvt), .gblLockEvt(gblLockEvt), .pwrDownReq(pwrDownReq),
    .rtcEvt(rtcEvt), .pciHpEvt(pciHpEvt), .cpuHpEvt(cpuHpEvt),
    .regRdData(regRdData), .sci(sci), .acpiMode(acpiMode), .timerArm(timerArm)
  );
endmodule

// File: tb/acpi_sci_ctrl_tb.sv
`timescale 1ns/1ps
module acpi_sci_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       apmWrEn = 1'b0;
  logic [7:0] apmData = '0;
  logic [7:0] smiCfg = '0;
  logic [3:0] evPm = '0;
  logic       pciHpEvt = 1'b0, cpuHpEvt = 1'b0;
  logic       sci, smiPulse, acpiMode, timerArm;
  int         checks = 0, errors = 0;

  always #2 clk = ~clk;

  acpi_sci_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .apmWrEn(apmWrEn),
    .apmData(apmData), .smiCfg(smiCfg), .tmrOvfEvt(evPm[0]),
    .gblLockEvt(evPm[1]), .pwrDownReq(evPm[2]), .rtcEvt(evPm[3]),
    .pciHpEvt(pciHpEvt), .cpuHpEvt(cpuHpEvt), .sci(sci),
    .smiPulse(smiPulse), .acpiMode(acpiMode), .timerArm(timerArm)
  );

  function automatic int bitPos(int i);
    case (i)
      0: return 0;
      1: return 5;
      2: return 8;
      default: return 10;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(int a, logic [7:0] d);
    regAddr = a[2:0]; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(int a, output logic [7:0] d);
    regAddr = a[2:0];
    #0.5;
    d = regRdData;
  endtask

  task automatic apmWr(logic [7:0] d);
    apmData = d; apmWrEn = 1'b1;
    tick();
    apmWrEn = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       modeExp;
    @(negedge clk);
    tick(); tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    check("R1 sci", sci, 0);
    check("R1 smi", smiPulse, 0);
    check("R1 mode", acpiMode, 0);
    check("R1 timerArm", timerArm, 0);
    for (int a = 0; a < 8; a++) begin
      rdReg(a, rd);
      check("R1 reg", rd, 0);
    end

    // R2 R6 R4: each PM1 source with enable off/on
    for (int i = 0; i < 4; i++) begin
      for (int e = 0; e < 2; e++) begin
        logic [15:0] m;
        m = 16'd1 << bitPos(i);
        wrReg(2, e ? m[7:0] : 8'h00);
        wrReg(3, e ? m[15:8] : 8'h00);
        evPm[i] = 1'b1; tick(); evPm[i] = 1'b0;
        tick();
        check("R2 sci per source", sci, e);
        rdReg(0, rd); check("R6 status lo", rd, m[7:0]);
        rdReg(1, rd); check("R6 status hi", rd, m[15:8]);
        wrReg(0, 8'h00); wrReg(1, 8'h00);
        rdReg(0, rd); check("R4 zero write keeps lo", rd, m[7:0]);
        rdReg(1, rd); check("R4 zero write keeps hi", rd, m[15:8]);
        wrReg(0, m[7:0]); wrReg(1, m[15:8]);
        tick();
        check("R4 sci after clear", sci, 0);
        rdReg(0, rd); check("R4 cleared lo", rd, 0);
        rdReg(1, rd); check("R4 cleared hi", rd, 0);
      end
    end

    // R2 enable combinations with all four sources pending
    evPm = 4'hF; tick(); evPm = 4'h0;
    for (int m = 0; m < 16; m++) begin
      logic [15:0] en;
      en = '0;
      for (int i = 0; i < 4; i++) if (m[i]) en |= 16'd1 << bitPos(i);
      wrReg(2, en[7:0]); wrReg(3, en[15:8]);
      tick();
      check("R2 enable combo", sci, (m != 0));
    end
    // R10 unimplemented bits
    wrReg(2, 8'hDE); wrReg(3, 8'hFA);
    tick();
    rdReg(2, rd); check("R10 en lo unimpl", rd, 8'h00);
    rdReg(3, rd); check("R10 en hi unimpl", rd, 8'h00);
    check("R10 sci unimpl enable", sci, 0);
    wrReg(0, 8'hFF); wrReg(1, 8'hFF);
    rdReg(7, rd); check("R10 reserved addr", rd, 0);

    // R3 GPE enable sweep
    pciHpEvt = 1'b1; cpuHpEvt = 1'b1; tick(); pciHpEvt = 1'b0; cpuHpEvt = 1'b0;
    rdReg(4, rd); check("R6 gpe status", rd, 8'h06);
    for (int v = 0; v < 256; v++) begin
      wrReg(5, v[7:0]);
      tick();
      check("R3 gpe enable sweep", sci, ((v & 6) != 0));
    end
    wrReg(4, 8'h02);
    rdReg(4, rd); check("R4 gpe w1c", rd, 8'h04);
    // R5 set wins over clear in the same cycle
    cpuHpEvt = 1'b1; wrReg(4, 8'h04); cpuHpEvt = 1'b0;
    rdReg(4, rd); check("R5 gpe set wins", rd, 8'h04);
    evPm[2] = 1'b1; wrReg(1, 8'h01); evPm[2] = 1'b0;
    rdReg(1, rd); check("R5 pm1 set wins", rd, 8'h01);
    wrReg(1, 8'h01); wrReg(4, 8'hFF); wrReg(5, 8'h00);

    // R9 timer arm
    wrReg(2, 8'h01);
    check("R9 arm on", timerArm, 1);
    evPm[0] = 1'b1; tick(); evPm[0] = 1'b0;
    check("R9 arm off when status set", timerArm, 0);
    wrReg(0, 8'h01);
    check("R9 arm back", timerArm, 1);
    wrReg(2, 8'h00);
    check("R9 arm off when disabled", timerArm, 0);

    // R7 R8 exhaustive APM command sweep
    modeExp = 1'b0;
    for (int c = 0; c < 2; c++) begin
      smiCfg = c ? 8'h02 : 8'hFD;
      for (int d = 0; d < 256; d++) begin
        apmWr(d[7:0]);
        if (d == 8'hF1) modeExp = 1'b1;
        else if (d == 8'hF0) modeExp = 1'b0;
        check("R8 smi pulse", smiPulse, c);
        check("R7 mode", acpiMode, modeExp);
        tick();
        check("R8 smi one cycle", smiPulse, 0);
        if (d == 8'hF1 || d == 8'hF2) begin
          rdReg(6, rd); check("R7 mode reg", rd, {7'd0, modeExp});
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule